// File: doc/BRIEF.md
# Phase-Offset Amplitude-Scaled Numerically Controlled Oscillator

This block produces a stream of signed sine samples, one per clock. An unsigned phase register advances by a frequency step word on every enabled cycle and wraps modulo 2^PHASE_W. A phase offset word is added to that phase, and the sum addresses a registered sine table. The table entry is then multiplied by a small unsigned amplitude word. The frequency of the output is step × f_clk / 2^PHASE_W. With a 10-bit phase, a 200 MHz clock and a step of 8, that gives 1.5625 MHz. The phase resolution is 360°/2^PHASE_W, about 1.41° at the default 8 bits.

The three control words are sampled every cycle, so a caller can modulate them directly. Moving the step word gives frequency keying. Moving the offset word by half the range gives a 180° phase flip. Moving the amplitude word gives amplitude keying. The path is pipelined with a register after every logic stage. Each control word reaches the output with the same fixed latency of four clocks.

The table is TAB_W = OUT_W − AMP_W bits wide (14 by default). Entry k holds round((2^(TAB_W−1)−1)·sin(2πk/2^PHASE_W)) in two's complement. This width ensures that the scaled product always fits the output width.

Top module: `phase_nco`

## Requirements
- R1: A synchronous active-low reset clears the phase register and every pipeline register, so the output reads 0 while reset is held. After release, with a step of 0 and an offset of 2^(PHASE_W−2), the output is the positive peak scaled by the amplitude word.
- R2: On every clock edge with enable high, the phase register advances by the step word modulo 2^PHASE_W. The output equals amplitude × table[(phase + offset) mod 2^PHASE_W].
- R3: On a clock edge with enable low, the phase register keeps its value, so the output stays constant while the other words are constant.
- R4: The offset word is added to the phase modulo 2^PHASE_W. An offset of 2^(PHASE_W−1) negates the sample.
- R5: The output is the signed table entry times the unsigned amplitude word. An amplitude of 0 gives 0, and no amplitude value overflows the output width or flips the sign.
- R6: A change of the step, offset or amplitude word sampled at clock edge E first appears at the output after edge E+3. That is a latency of four registers.
- R7: A step of 0 with enable high gives a constant output.
- R8: Table address 2^(PHASE_W−2) holds +(2^(TAB_W−1)−1), address 3·2^(PHASE_W−2) holds −(2^(TAB_W−1)−1), and address 0 holds 0.
- R9: For a step S that divides 2^PHASE_W, the output repeats every 2^PHASE_W/S cycles. Half that many cycles later the output is the negated sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advances the phase register when high |
| step_word | input | PHASE_W | Phase increment per enabled cycle (frequency) |
| offset_word | input | PHASE_W | Phase offset added after the accumulator |
| amp_word | input | AMP_W | Unsigned amplitude multiplier |
| sample | output | OUT_W | Signed sine sample |

## Verification
A phase register that takes a wrong step or ignores enable shows up in the output four clocks later, as a sample that differs from the stepped reference. It also breaks the period and the half-period sign flip. An offset adder or table error shows within four clocks as a wrong value at a known phase, most clearly at the quarter-range peaks. A misaligned amplitude delay shows as a scale change that arrives one cycle early or late around an amplitude step from 0.

// File: rtl/nco_pkg.sv
// Package: shared constants and the sine-code function used to fill the table.
// Assumes the function is only evaluated at elaboration time (constant inputs).
package nco_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Rounded, signed sine code for phase index k of 2^pw, amplitude 2^(tw-1)-1.
    function automatic int sine_code(input int k, input int pw, input int tw);
        real amp;
        real val;
        amp = (2.0 ** (tw - 1)) - 1.0;
        val = amp * $sin(TWO_PI * k / (2.0 ** pw));
        if (val >= 0.0)
            return $rtoi(val + 0.5);
        else
            return $rtoi(val - 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_path.sv
// Phase path: stage 1 accumulates the step word while enabled, stage 2 adds
// the offset word (delayed one cycle so it stays aligned with the accumulator).
// Assumes both additions wrap modulo 2^PHASE_W by plain truncation.
module nco_phase_path #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PHASE_W-1:0] step_word,
    input  logic [PHASE_W-1:0] offset_word,
    output logic [PHASE_W-1:0] phase_q
);

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] offset_d;

    // Stage 1: phase accumulator plus alignment register for the offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            offset_d <= '0;
        end else begin
            if (en)
                acc_q <= acc_q + step_word;
            offset_d <= offset_word;
        end
    end

    // Stage 2: offset addition, wrapped to the phase width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else
            phase_q <= acc_q + offset_d;
    end

    // R3: with enable low the accumulator keeps its value
    a_r3_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> acc_q == $past(acc_q));

endmodule

// File: rtl/nco_sine_rom.sv
// Sine table: one signed entry per phase address, computed at elaboration,
// read through an output register. Assumes TAB_W >= 2.
module nco_sine_rom #(
    parameter int PHASE_W = 8,
    parameter int TAB_W   = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PHASE_W-1:0]       addr,
    output logic signed [TAB_W-1:0]  code_q
);

    localparam int DEPTH = 1 << PHASE_W;
    localparam logic signed [TAB_W-1:0] MOST_NEG = {1'b1, {(TAB_W-1){1'b0}}};

    logic signed [TAB_W-1:0] table_w [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        localparam int VAL = nco_pkg::sine_code(k, PHASE_W, TAB_W);
        assign table_w[k] = TAB_W'(VAL);
    end

    // Stage 3: registered table read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else
            code_q <= table_w[addr];
    end

    // R8: symmetric amplitude, the most negative code never appears
    a_r8_symmetric_code: assert property (@(posedge clk) disable iff (!rst_n)
        code_q != MOST_NEG);

endmodule

// File: rtl/nco_scale.sv
// Amplitude stage: delays the amplitude word to line up with the table read,
// then multiplies signed table code by unsigned amplitude into the output.
// Assumes OUT_W = TAB_W + AMP_W, so the product always fits.
module nco_scale #(
    parameter int TAB_W = 14,
    parameter int AMP_W = 2,
    parameter int DLY   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [AMP_W-1:0]              amp_word,
    input  logic signed [TAB_W-1:0]       code_q,
    output logic signed [TAB_W+AMP_W-1:0] sample_q
);

    localparam int OUT_W = TAB_W + AMP_W;

    logic [AMP_W-1:0] amp_pipe [DLY+1];
    logic signed [OUT_W-1:0] product;

    assign amp_pipe[0] = amp_word;

    for (genvar i = 0; i < DLY; i++) begin : g_amp_dly
        // Alignment delay for the amplitude word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                amp_pipe[i+1] <= '0;
            else
                amp_pipe[i+1] <= amp_pipe[i];
        end
    end

    assign product = $signed(OUT_W'(code_q)) * $signed(OUT_W'({1'b0, amp_pipe[DLY]}));

    // Stage 4: registered scaled sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_q <= '0;
        else
            sample_q <= product;
    end

    // R5: scaling a positive code by a non-zero amplitude never wraps negative
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_q) > 0 && $past(amp_pipe[DLY]) != 0) |-> sample_q > 0);

endmodule

// File: rtl/phase_nco.sv
// Top: phase path, sine table and amplitude stage in a four-register pipeline.
// Assumes OUT_W > AMP_W; table width is derived as OUT_W - AMP_W.
module phase_nco #(
    parameter int PHASE_W = 8,
    parameter int AMP_W   = 2,
    parameter int OUT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [PHASE_W-1:0]       step_word,
    input  logic [PHASE_W-1:0]       offset_word,
    input  logic [AMP_W-1:0]         amp_word,
    output logic signed [OUT_W-1:0]  sample
);

    localparam int TAB_W   = OUT_W - AMP_W;
    localparam int LATENCY = 4;

    logic [PHASE_W-1:0]      phase_q;
    logic signed [TAB_W-1:0] code_q;
    logic [2:0]              fill_q;

    nco_phase_path #(.PHASE_W(PHASE_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step_word  (step_word),
        .offset_word(offset_word),
        .phase_q    (phase_q)
    );

    nco_sine_rom #(.PHASE_W(PHASE_W), .TAB_W(TAB_W)) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (phase_q),
        .code_q(code_q)
    );

    nco_scale #(.TAB_W(TAB_W), .AMP_W(AMP_W), .DLY(LATENCY-1)) u_scale (
        .clk     (clk),
        .rst_n   (rst_n),
        .amp_word(amp_word),
        .code_q  (code_q),
        .sample_q(sample)
    );

    // Counts cycles since reset up to the pipeline depth, for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (fill_q < 3'(LATENCY))
            fill_q <= fill_q + 3'd1;
    end

    // R5, R6: a zero amplitude sampled four edges back forces a zero sample
    a_r5_zero_amplitude: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q >= 3'(LATENCY) && $past(amp_word, 4) == '0) |-> sample == '0);

    // R1: the first sample after reset release is still the cleared value
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == 3'd0) |-> sample == '0);

endmodule

// File: tb/phase_nco_tb.sv
module phase_nco_tb;

    localparam int CLK_NS = 10;
    localparam int PW     = 8;
    localparam int AW     = 2;
    localparam int OW     = 16;
    localparam int TW     = OW - AW;
    localparam int MASK   = (1 << PW) - 1;
    localparam int PEAK   = (1 << (TW - 1)) - 1;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  en = 1'b0;
    logic [PW-1:0]         step_word = '0;
    logic [PW-1:0]         offset_word = '0;
    logic [AW-1:0]         amp_word = '0;
    logic signed [OW-1:0]  sample;

    typedef struct {
        int    due;
        int    exp;
        string tag;
    } item_t;

    item_t sbq[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    m_acc = 0;
    bit    done = 1'b0;
    int    hist[256];

    phase_nco #(.PHASE_W(PW), .AMP_W(AW), .OUT_W(OW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step_word  (step_word),
        .offset_word(offset_word),
        .amp_word   (amp_word),
        .sample     (sample)
    );

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_sine(input int k);
        real v;
        v = (2.0 ** (TW - 1) - 1.0) * $sin(6.283185307179586 * k / (2.0 ** PW));
        return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of inputs and push the expected sample with its due cycle.
    task automatic step_x(input bit e, input int f, input int p, input int a,
                          input bit use_x, input int xexp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        en          = e;
        step_word   = PW'(f);
        offset_word = PW'(p);
        amp_word    = AW'(a);
        if (e) m_acc = (m_acc + f) & MASK;
        it.due = cyc + 4;
        it.exp = use_x ? xexp : ref_sine((m_acc + p) & MASK) * a;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic step(input bit e, input int f, input int p, input int a, input string tag);
        step_x(e, f, p, a, 1'b0, 0, tag);
    endtask

    // Monitor: compare every due item at the falling edge.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            item_t it;
            it = sbq.pop_front();
            check(int'(sample) == it.exp, it.tag, int'(sample), it.exp);
        end
    end

    task automatic drain();
        while (sbq.size() > 0) @(negedge clk);
    endtask

    // R1: hold reset with live inputs, check cleared output, then release quietly.
    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0; en = 1'b1; step_word = 8'd5; offset_word = 8'd9; amp_word = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sample == '0, "R1", int'(sample), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1; en = 1'b0; step_word = '0; offset_word = '0; amp_word = '0;
        m_acc = 0;
    endtask

    // R9: run at a fixed step, record samples, check period and half-period negation.
    task automatic period_run(input int f);
        int per;
        per = (1 << PW) / f;
        for (int i = 0; i < 2 * per + 8; i++) begin
            step(1'b1, f, 0, 3, "R2");
            @(negedge clk);
            hist[i] = int'(sample);
        end
        for (int j = 0; j < 4; j++) begin
            int i0;
            i0 = 6 + j * (per / 4);
            check(hist[i0 + per] == hist[i0], "R9", hist[i0 + per], hist[i0]);
            check(hist[i0 + per/2] == -hist[i0], "R9", hist[i0 + per/2], -hist[i0]);
        end
    endtask

    initial begin
        do_reset();
        // R1: accumulator cleared, so offset of a quarter range gives the peak
        step(1'b1, 0, 64, 1, "R1");
        step(1'b1, 0, 64, 1, "R1");
        // R2: steady stepping with wrap-around
        for (int i = 0; i < 100; i++) step(1'b1, 3, 0, 1, "R2");
        for (int i = 0; i < 20; i++) step(1'b1, 77, 11, 2, "R2");
        // R5: amplitude cycling through all values including 0
        for (int i = 0; i < 40; i++) step(1'b1, 7, 0, i % 4, "R5");
        // R3: enable low holds the phase
        for (int i = 0; i < 10; i++) step(1'b0, 9, 0, 2, "R3");
        // R4: offset flips by half the range
        for (int i = 0; i < 32; i++) step(1'b1, 5, ((i / 8) % 2) * 128, 3, "R4");
        for (int i = 0; i < 6; i++) step(1'b1, 0, 40 + (i % 2) * 128, 1, "R4");
        // R6: amplitude step from 0 appears exactly four registers later
        for (int i = 0; i < 6; i++) step(1'b1, 0, 64, 0, "R6");
        for (int i = 0; i < 6; i++) step(1'b1, 0, 64, 3, "R6");
        // R7: zero step gives a constant sample
        for (int i = 0; i < 20; i++) step(1'b1, 0, 37, 2, "R7");
        // R8: table landmarks with explicit values
        drain();
        m_acc = 0;
        do_reset();
        for (int i = 0; i < 5; i++) step_x(1'b1, 0, 64, 1, 1'b1, PEAK, "R8");
        for (int i = 0; i < 5; i++) step_x(1'b1, 0, 192, 1, 1'b1, -PEAK, "R8");
        for (int i = 0; i < 5; i++) step_x(1'b1, 0, 0, 3, 1'b1, 0, "R8");
        // R9: periods for several step values
        period_run(8);
        period_run(16);
        period_run(4);
        // R1: mid-run reset clears the accumulator again
        for (int i = 0; i < 13; i++) step(1'b1, 11, 0, 1, "R2");
        drain();
        do_reset();
        step(1'b1, 0, 64, 2, "R1");
        step(1'b1, 0, 64, 2, "R1");
        drain();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule